// File: doc/BRIEF.md
# Serial Port Character Queue Controller

This block sits between the serial shift logic and the bus of a classic asynchronous serial port. It holds two character queues: one for received characters and one for characters waiting to be sent. A byte-wide control register sets how the queues behave. One bit turns both queues on and off, and any change of that bit empties both queues. Two self-clearing command bits empty one queue at a time. A two-bit field picks the receive fill level that raises an interrupt.

A small state machine keeps the enable state. It has two states, `ST_OFF` and `ST_ON`, and two transitions:

- `ST_OFF -> ST_ON` happens on a control write with bit 0 set. It empties both queues.
- `ST_ON -> ST_OFF` happens on a control write with bit 0 clear. It also empties both queues.

A write that leaves the state unchanged does not move it. The receive interrupt is a level signal. It is high while the receive queue holds at least the selected number of characters and the machine is in `ST_ON`.

Top module: `sio_queue_ctrl`

## Requirements
- R1: After reset, `cfg_q` reads 0x00, both counts are 0, both overrun flags are 0 and `rx_trig_irq` is 0.
- R2: A control write whose bit 0 differs from the current enable state (`cfg_q[0]`) moves the enable state to the new value and empties both queues. A write with bit 0 equal to the current state empties neither queue on account of bit 0.
- R3: A write with bits 0 and 1 both set empties the receive queue and leaves the transmit queue untouched. Bit 1 always reads back as 0.
- R4: A write with bits 0 and 2 both set empties the transmit queue and leaves the receive queue untouched. Bit 2 always reads back as 0.
- R5: Control bits 7:6 select the receive trigger level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. `rx_trig_irq` is high exactly when the state is on and `rx_count` is at or above the selected level. The readback shows the field in `cfg_q[7:6]`.
- R6: Bits 5:3 of a control write have no effect, and `cfg_q[5:3]` always reads 0.
- R7: Bits 7:1 of a control write take effect only if bit 0 of the same write is 1. Otherwise the trigger field keeps its value and no single-queue empty occurs.
- R8: Each queue holds 16 characters in first-in first-out order. A pop of a non-empty queue places the head character on its `*_dout` after the same clock edge, and `*_count` follows pushes and pops.
- R9: A push to a full queue is dropped and sets that queue's sticky overrun flag. The flag clears only when that queue is emptied by a control write, or on reset.
- R10: A pop of an empty queue leaves `*_dout` and `*_count` unchanged.
- R11: A push in the same cycle as an empty command for that queue leaves the queue empty.
- R12: While the state is off, pushes and pops are ignored and `rx_trig_irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_data | input | 8 | Control write data |
| cfg_q | output | 8 | Control readback: {trigger[1:0], 5'b0, enable} |
| rx_push | input | 1 | Push a received character |
| rx_din | input | 8 | Received character |
| rx_pop | input | 1 | Pop the receive queue head |
| rx_dout | output | 8 | Last character popped from the receive queue |
| rx_count | output | 5 | Receive queue occupancy |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| rx_trig_irq | output | 1 | Receive trigger level interrupt |
| tx_push | input | 1 | Push a character to send |
| tx_din | input | 8 | Character to send |
| tx_pop | input | 1 | Pop the transmit queue head |
| tx_dout | output | 8 | Last character popped from the transmit queue |
| tx_count | output | 5 | Transmit queue occupancy |
| tx_overrun | output | 1 | Sticky transmit overrun flag |

## Verification
All results take effect at the first rising edge after the inputs are presented. Control writes update `cfg_q`, both counts and the overrun flags at that edge. A pop loads `*_dout` at that same edge. `rx_trig_irq` is decoded from registered state, so it is valid in the same cycle as the count it depends on. The bench drives every stimulus just after a rising edge and reads results one time unit after the next rising edge, so each check looks exactly one edge after its stimulus. The sweep runs over all four trigger codes and every fill level from 0 to 16, and compares against levels and data computed arithmetically.

// File: rtl/sio_queue_pkg.sv
package sio_queue_pkg;

    typedef enum logic [0:0] {
        ST_OFF = 1'b0,
        ST_ON  = 1'b1
    } qctl_state_t;

    localparam int CFG_W = 8;

    // Receive fill level selected by the two-bit trigger code
    function automatic int unsigned trig_depth(input logic [1:0] sel);
        int unsigned lvl;
        unique case (sel)
            2'b00: lvl = 1;
            2'b01: lvl = 4;
            2'b10: lvl = 8;
            default: lvl = 14;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/sio_qctl_fsm.sv
module sio_qctl_fsm
    import sio_queue_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_data,
    output logic             fifo_on,
    output logic             flush_rx,
    output logic             flush_tx,
    output logic [1:0]       trig_sel,
    output logic [CFG_W-1:0] cfg_q
);

    qctl_state_t state_q, state_d;
    logic [1:0]  trig_q;
    logic        wr_on;
    logic        toggle;
    logic        unused_rsvd;

    assign unused_rsvd = ^cfg_data[5:3];
    assign wr_on       = cfg_wr && cfg_data[0];

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (cfg_wr && cfg_data[0])  state_d = ST_ON;
            ST_ON:  if (cfg_wr && !cfg_data[0]) state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    // State register and trigger field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            trig_q  <= 2'b00;
        end else begin
            state_q <= state_d;
            if (wr_on) trig_q <= cfg_data[7:6];
        end
    end

    // Outputs
    always_comb begin
        fifo_on  = (state_q == ST_ON);
        toggle   = cfg_wr && (cfg_data[0] != fifo_on);
        flush_rx = toggle || (wr_on && cfg_data[1]);
        flush_tx = toggle || (wr_on && cfg_data[2]);
        trig_sel = trig_q;
        cfg_q    = {trig_q, 5'b00000, fifo_on};
    end

    // R7
    trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_data[0]) |=> $stable(trig_q));

endmodule

// File: rtl/sio_char_fifo.sv
module sio_char_fifo #(
    parameter  int DATA_W = 8,
    parameter  int DEPTH  = 16,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic [CNT_W-1:0]  count,
    output logic              overrun
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              full, empty, do_push, do_pop;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            overrun <= 1'b0;
            dout    <= '0;
        end else if (flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + PTR_W'(1);
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + PTR_W'(1);
                dout   <= mem[rd_ptr];
            end
            if (do_push && !do_pop)      count <= count + CNT_W'(1);
            else if (do_pop && !do_push) count <= count - CNT_W'(1);
            if (push && full) overrun <= 1'b1;
        end
    end

    // R8
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R11
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0) && !overrun);

    // R9
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !flush) |=> overrun);

    // R10
    empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !flush && !push) |=> $stable(dout) && (count == '0));

endmodule

// File: rtl/sio_trig_cmp.sv
module sio_trig_cmp
    import sio_queue_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             on,
    input  logic [1:0]       sel,
    input  logic [CNT_W-1:0] count,
    output logic             irq
);

    logic [CNT_W-1:0] level;

    always_comb begin
        level = CNT_W'(trig_depth(sel));
        irq   = on && (count >= level);
    end

    // R12
    irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !on |-> !irq);

endmodule

// File: rtl/sio_queue_ctrl.sv
module sio_queue_ctrl
    import sio_queue_pkg::*;
#(
    parameter  int DATA_W = 8,
    parameter  int DEPTH  = 16,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_data,
    output logic [7:0]        cfg_q,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_din,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_dout,
    output logic [CNT_W-1:0]  rx_count,
    output logic              rx_overrun,
    output logic              rx_trig_irq,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_din,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_dout,
    output logic [CNT_W-1:0]  tx_count,
    output logic              tx_overrun
);

    logic       fifo_on, flush_rx, flush_tx;
    logic [1:0] trig_sel;

    sio_qctl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_data (cfg_data),
        .fifo_on  (fifo_on),
        .flush_rx (flush_rx),
        .flush_tx (flush_tx),
        .trig_sel (trig_sel),
        .cfg_q    (cfg_q)
    );

    sio_char_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush_rx),
        .push    (rx_push && fifo_on),
        .din     (rx_din),
        .pop     (rx_pop && fifo_on),
        .dout    (rx_dout),
        .count   (rx_count),
        .overrun (rx_overrun)
    );

    sio_char_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush_tx),
        .push    (tx_push && fifo_on),
        .din     (tx_din),
        .pop     (tx_pop && fifo_on),
        .dout    (tx_dout),
        .count   (tx_count),
        .overrun (tx_overrun)
    );

    sio_trig_cmp #(.CNT_W(CNT_W)) u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .on    (fifo_on),
        .sel   (trig_sel),
        .count (rx_count),
        .irq   (rx_trig_irq)
    );

    // R2
    toggle_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (cfg_data[0] != cfg_q[0])) |=> (rx_count == '0) && (tx_count == '0));

    // R5
    top_level_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[0] && rx_count >= CNT_W'(14)) |-> rx_trig_irq);

    // R12
    off_push_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q[0] && !cfg_wr) |=> (rx_count == '0) && (tx_count == '0));

endmodule

// File: tb/sio_queue_ctrl_bench.sv
`timescale 1ns/1ps
module sio_queue_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_wr;
    logic [7:0] cfg_data, cfg_q;
    logic       rx_push, rx_pop, tx_push, tx_pop;
    logic [7:0] rx_din, tx_din, rx_dout, tx_dout;
    logic [4:0] rx_count, tx_count;
    logic       rx_overrun, tx_overrun, rx_trig_irq;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;

    sio_queue_ctrl u_sio_queue_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data), .cfg_q(cfg_q),
        .rx_push(rx_push), .rx_din(rx_din), .rx_pop(rx_pop), .rx_dout(rx_dout),
        .rx_count(rx_count), .rx_overrun(rx_overrun), .rx_trig_irq(rx_trig_irq),
        .tx_push(tx_push), .tx_din(tx_din), .tx_pop(tx_pop), .tx_dout(tx_dout),
        .tx_count(tx_count), .tx_overrun(tx_overrun)
    );

    task automatic idle();
        cfg_wr = 0; cfg_data = 8'h00;
        rx_push = 0; rx_pop = 0; rx_din = 8'h00;
        tx_push = 0; tx_pop = 0; tx_din = 8'h00;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        cfg_wr = 1; cfg_data = v;
        tick();
    endtask

    task automatic push_rx(input logic [7:0] v);
        rx_push = 1; rx_din = v;
        tick();
    endtask

    task automatic push_tx(input logic [7:0] v);
        tx_push = 1; tx_din = v;
        tick();
    endtask

    function automatic int lvl_of(input int sel);
        return (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 8 : 14;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        chk("R1", "cfg_q", cfg_q, 0);
        chk("R1", "rx_count", rx_count, 0);
        chk("R1", "tx_count", tx_count, 0);
        chk("R1", "irq", rx_trig_irq, 0);
        chk("R1", "overruns", {rx_overrun, tx_overrun}, 0);

        // R12 pushes ignored while off
        rx_push = 1; rx_din = 8'h55; tx_push = 1; tx_din = 8'h66;
        tick();
        chk("R12", "rx_count off", rx_count, 0);
        chk("R12", "tx_count off", tx_count, 0);
        chk("R12", "irq off", rx_trig_irq, 0);

        // R7 write with bit0 clear changes nothing
        wr_cfg(8'hFE);
        chk("R7", "cfg_q after FE", cfg_q, 0);

        // R5 R8 R9 R10 R6 sweep over all trigger codes
        for (int sel = 0; sel < 4; sel++) begin
            wr_cfg(8'((sel << 6) | 8'h39));
            chk("R6", "cfg_q reserved", cfg_q, (sel << 6) | 1);
            chk("R5", "irq empty", rx_trig_irq, 0);
            for (int k = 0; k < 16; k++) begin
                push_rx(8'(sel * 16 + k + 8'h20));
                chk("R8", "rx_count fill", rx_count, k + 1);
                chk("R5", "irq level", rx_trig_irq, ((k + 1) >= lvl_of(sel)) ? 1 : 0);
            end
            chk("R9", "no overrun yet", rx_overrun, 0);
            push_rx(8'hEE);
            chk("R9", "count full", rx_count, 16);
            chk("R9", "overrun set", rx_overrun, 1);
            for (int k = 0; k < 16; k++) begin
                rx_pop = 1;
                tick();
                chk("R8", "rx_dout order", rx_dout, sel * 16 + k + 8'h20);
                chk("R8", "rx_count drain", rx_count, 15 - k);
            end
            chk("R9", "overrun sticky", rx_overrun, 1);
            rx_pop = 1;
            tick();
            chk("R10", "dout hold", rx_dout, sel * 16 + 15 + 8'h20);
            chk("R10", "count hold", rx_count, 0);
            wr_cfg(8'((sel << 6) | 8'h03));
            chk("R3", "overrun cleared", rx_overrun, 0);
            chk("R3", "bit1 reads 0", cfg_q, (sel << 6) | 1);
        end

        // R4 / R3 single-queue empties
        wr_cfg(8'h01);
        for (int k = 0; k < 5; k++) begin
            rx_push = 1; rx_din = 8'(k); tx_push = 1; tx_din = 8'(k + 8'h40);
            tick();
        end
        wr_cfg(8'h05);
        chk("R4", "tx emptied", tx_count, 0);
        chk("R4", "rx untouched", rx_count, 5);
        chk("R4", "bit2 reads 0", cfg_q, 1);
        wr_cfg(8'h01);
        chk("R2", "no toggle keeps rx", rx_count, 5);
        wr_cfg(8'h03);
        chk("R3", "rx emptied", rx_count, 0);

        // R11 push with simultaneous empty
        push_rx(8'h11);
        rx_push = 1; rx_din = 8'h22; cfg_wr = 1; cfg_data = 8'h03;
        tick();
        chk("R11", "rx empty after push+flush", rx_count, 0);
        push_tx(8'h33);
        tx_push = 1; tx_din = 8'h44; cfg_wr = 1; cfg_data = 8'h05;
        tick();
        chk("R11", "tx empty after push+flush", tx_count, 0);

        // R8 transmit order
        for (int k = 0; k < 4; k++) push_tx(8'(8'hA0 + k));
        for (int k = 0; k < 4; k++) begin
            tx_pop = 1;
            tick();
            chk("R8", "tx_dout order", tx_dout, 8'hA0 + k);
        end

        // R2 falling transition empties and R7 keeps trigger
        wr_cfg(8'h81);
        push_rx(8'h01); push_rx(8'h02); push_rx(8'h03);
        push_tx(8'h04);
        wr_cfg(8'hC6);
        chk("R2", "off rx emptied", rx_count, 0);
        chk("R2", "off tx emptied", tx_count, 0);
        chk("R7", "trigger kept", cfg_q, 8'h80);
        chk("R12", "irq off", rx_trig_irq, 0);
        wr_cfg(8'h01);
        chk("R2", "on again", cfg_q, 1);
        push_rx(8'h09);
        chk("R5", "irq lvl1", rx_trig_irq, 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule